// File: doc/BRIEF.md
# Timer Clock Prescaler with Reset

This block produces the count-enable strobe for an 8-bit timer. A 10-bit prescaler counter runs freely. A 3-bit select value picks the strobe rate: none at all, every clock, or once every 8, 32, 64, 128, 256 or 1024 clocks. Each strobe is a single-cycle pulse on the clock that drives the prescaler. It is never a divided clock.

A source bit chooses where the prescaler runs. With the bit low, it runs on the system clock and drives `tick_sys`. With the bit high, it runs on a separate oscillator clock and drives `tick_osc`. The timer that consumes the strobe must be clocked by the same clock as the strobe it uses.

Software can restart the prescaler by writing one to a self-clearing reset bit.
- In system-clock mode, the counter restarts on the next edge and the bit reads back as zero.
- In oscillator mode, the request crosses into the oscillator domain through a two-flop synchronizer, and an acknowledgement returns through a second synchronizer. The bit reads as one until the oscillator-side restart has been confirmed back in the system domain.

The select field is treated as quasi-static configuration.

Top module: `tmr_prescaler`

## Requirements
- R1: The select code sets the strobe period N as follows: 0 = no strobe, 1 = every cycle, 2 = 8, 3 = 32, 4 = 64, 5 = 128, 6 = 256, 7 = 1024. Each strobe is exactly one cycle wide.
- R2: A strobe is high in the cycle that follows every N-th clock edge counted from the edge that restarted the prescaler. It is never high in the cycle after the restart edge itself.
- R3: With select code 0, no strobe appears, but the counter keeps advancing. Leaving code 0 without a restart therefore keeps the strobe phase measured from the last restart.
- R4: In system-clock mode, a write of one restarts the prescaler on the edge that takes the write.
- R5: A write of zero to the reset bit changes neither the strobe phase nor the readback.
- R6: In system-clock mode, `clr_rd` is always zero, including during the write cycle.
- R7: In oscillator mode, `clr_rd` reads one from the cycle after a write of one. It returns to zero only after the oscillator-side restart has been acknowledged, within a few cycles of both clocks.
- R8: In oscillator mode, a restart request clears the oscillator-domain counter. The first strobe at N = 1024 then appears between 1024 and 1034 oscillator edges after the write.
- R9: Only the prescaler on the selected clock runs. `tick_sys` stays low in oscillator mode, and `tick_osc` stays low in system-clock mode.
- R10: While reset is asserted, `tick_sys`, `tick_osc` and `clr_rd` are all low.
- R11: A second write of one while a handshake is still pending is not lost. `clr_rd` stays one and later falls back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_sys_n | input | 1 | Asynchronous active-low reset; it also resets the oscillator domain |
| clk_osc | input | 1 | Asynchronous oscillator clock |
| src_async | input | 1 | 1: prescaler runs on `clk_osc`; 0: on `clk_sys` |
| tap_sel | input | 3 | Strobe rate select code |
| clr_wr | input | 1 | Write strobe for the reset bit |
| clr_wdata | input | 1 | Value written to the reset bit |
| clr_rd | output | 1 | Readback of the reset bit |
| tick_sys | output | 1 | Single-cycle strobe in the system domain |
| tick_osc | output | 1 | Single-cycle strobe in the oscillator domain |

## Verification
A corrupted prescaler count shows up as a strobe whose spacing or phase is wrong. At the fast rates this is visible within one period, but at N = 1024 it can take up to 1024 cycles to show. That is why the bench measures the phase from a known restart edge and does not only count pulses. A handshake stuck in the pending state shows up as `clr_rd` held at one past a bound of a few hundred system cycles. A restart that never reaches the oscillator domain shows up as the first oscillator strobe arriving hundreds of edges too early.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_TAPS = 6;

  typedef enum logic [SEL_W-1:0] {
    SEL_STOP    = 3'd0,
    SEL_DIV1    = 3'd1,
    SEL_DIV8    = 3'd2,
    SEL_DIV32   = 3'd3,
    SEL_DIV64   = 3'd4,
    SEL_DIV128  = 3'd5,
    SEL_DIV256  = 3'd6,
    SEL_DIV1024 = 3'd7
  } tap_sel_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_DONE = 2'd2
  } hs_state_e;

  // log2 of the divide ratio for divided tap index t (select code t+2)
  function automatic int unsigned tap_log2(input int unsigned t);
    case (t)
      0:       return 3;
      1:       return 5;
      2:       return 6;
      3:       return 7;
      4:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tps_sync.sv
module tps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tps_div.sv
module tps_div
  import tps_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cnt_d;
  logic                tick_q;
  logic                tick_d;
  logic [NUM_TAPS-1:0] tap_hit;

  // one boundary detector per divided tap: low bits all ones means the
  // next increment crosses that power-of-two boundary
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam int unsigned LW = tap_log2(t);
    if (LW > CNT_W) begin : g_absent
      assign tap_hit[t] = 1'b0;
    end else begin : g_present
      assign tap_hit[t] = &cnt_q[LW-1:0];
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (clr || !run) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      case (sel)
        SEL_STOP: tick_d = 1'b0;
        SEL_DIV1: tick_d = 1'b1;
        default:  tick_d = tap_hit[sel - 3'd2];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/tps_clr_hs.sv
module tps_clr_hs
  import tps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack_s,
  output logic req,
  output logic busy
);
  hs_state_e state_q;
  hs_state_e state_d;
  logic      again_q;
  logic      again_d;

  always_comb begin
    state_d = state_q;
    again_d = again_q;
    case (state_q)
      HS_IDLE: begin
        if (start) state_d = HS_REQ;
      end
      HS_REQ: begin
        // a write here may postdate the far-side clear: queue one more round
        if (start) again_d = 1'b1;
        if (ack_s) state_d = HS_DONE;
      end
      HS_DONE: begin
        if (start) again_d = 1'b1;
        if (!ack_s) begin
          state_d = (again_q || start) ? HS_REQ : HS_IDLE;
          again_d = 1'b0;
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      again_q <= 1'b0;
    end else begin
      state_q <= state_d;
      again_q <= again_d;
    end
  end

  assign req  = (state_q == HS_REQ);
  assign busy = (state_q == HS_REQ) || ((state_q == HS_DONE) && again_q);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tps_pkg::*;
#(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_sys,
  input  logic             rst_sys_n,
  input  logic             clk_osc,
  input  logic             src_async,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             clr_wr,
  input  logic             clr_wdata,
  output logic             clr_rd,
  output logic             tick_sys,
  output logic             tick_osc
);
  logic wr_one;
  logic clr_sys;
  logic hs_start;
  logic hs_req;
  logic hs_busy;
  logic ack_sys;
  logic rst_osc_n;
  logic run_osc;
  logic req_osc;
  logic req_osc_q;
  logic clr_osc;

  assign wr_one   = clr_wr && clr_wdata;
  assign clr_sys  = wr_one && !src_async;
  assign hs_start = wr_one && src_async;

  // ---------------- system domain ----------------
  tps_div #(.CNT_W(CNT_W)) u_div_sys (
    .clk   (clk_sys),
    .rst_n (rst_sys_n),
    .run   (!src_async),
    .clr   (clr_sys),
    .sel   (tap_sel),
    .tick  (tick_sys)
  );

  tps_clr_hs u_hs (
    .clk   (clk_sys),
    .rst_n (rst_sys_n),
    .start (hs_start),
    .ack_s (ack_sys),
    .req   (hs_req),
    .busy  (hs_busy)
  );

  tps_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk   (clk_sys),
    .rst_n (rst_sys_n),
    .d     (req_osc_q),
    .q     (ack_sys)
  );

  assign clr_rd = src_async && hs_busy;

  // ---------------- oscillator domain ----------------
  tps_sync #(.STAGES(SYNC_STAGES)) u_sync_rst (
    .clk   (clk_osc),
    .rst_n (rst_sys_n),
    .d     (1'b1),
    .q     (rst_osc_n)
  );

  tps_sync #(.STAGES(SYNC_STAGES)) u_sync_src (
    .clk   (clk_osc),
    .rst_n (rst_osc_n),
    .d     (src_async),
    .q     (run_osc)
  );

  tps_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
    .clk   (clk_osc),
    .rst_n (rst_osc_n),
    .d     (hs_req),
    .q     (req_osc)
  );

  always_ff @(posedge clk_osc or negedge rst_osc_n) begin
    if (!rst_osc_n) begin
      req_osc_q <= 1'b0;
    end else begin
      req_osc_q <= req_osc;
    end
  end

  // restart on the rising edge of the synchronized request; the registered
  // request doubles as the acknowledge returned to the system domain
  assign clr_osc = req_osc && !req_osc_q;

  tps_div #(.CNT_W(CNT_W)) u_div_osc (
    .clk   (clk_osc),
    .rst_n (rst_osc_n),
    .run   (run_osc),
    .clr   (clr_osc),
    .sel   (tap_sel),
    .tick  (tick_osc)
  );
endmodule

// File: rtl/tmr_prescaler_chk.sv
module tmr_prescaler_chk
  import tps_pkg::*;
(
  input logic             clk_sys,
  input logic             rst_sys_n,
  input logic             clk_osc,
  input logic             rst_osc_n,
  input logic             src_async,
  input logic [SEL_W-1:0] tap_sel,
  input logic             clr_wr,
  input logic             clr_wdata,
  input logic             clr_rd,
  input logic             tick_sys,
  input logic             tick_osc,
  input logic             run_osc
);
  a_r9_sys_quiet_async: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    $past(src_async) |-> !tick_sys);

  a_r3_stop_no_tick: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    ($past(tap_sel) == 3'd0) |-> !tick_sys);

  a_r4_restart_quiet: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    $past(clr_wr && clr_wdata && !src_async) |-> !tick_sys);

  a_r7_busy_from_write: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    $rose(clr_rd) |-> $past(clr_wr && clr_wdata));

  a_r9_osc_quiet_sys: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
    $past(!run_osc) |-> !tick_osc);
endmodule

bind tmr_prescaler tmr_prescaler_chk chk_i (
  .clk_sys   (clk_sys),
  .rst_sys_n (rst_sys_n),
  .clk_osc   (clk_osc),
  .rst_osc_n (rst_osc_n),
  .src_async (src_async),
  .tap_sel   (tap_sel),
  .clr_wr    (clr_wr),
  .clr_wdata (clr_wdata),
  .clr_rd    (clr_rd),
  .tick_sys  (tick_sys),
  .tick_osc  (tick_osc),
  .run_osc   (run_osc)
);

// File: tb/tmr_prescaler_tb_top.sv
`timescale 1ns/1ps
module tmr_prescaler_tb_top;
  logic       clk_sys = 1'b0;
  logic       clk_osc = 1'b0;
  logic       rst_sys_n = 1'b0;
  logic       src_async = 1'b0;
  logic [2:0] tap_sel = 3'd0;
  logic       clr_wr = 1'b0;
  logic       clr_wdata = 1'b0;
  logic       clr_rd;
  logic       tick_sys;
  logic       tick_osc;

  int n_run = 0;
  int n_fail = 0;
  int k = 0;
  int osc_n = 0;
  int osc_gap = 0;
  int sys_ticks = 0;
  int osc_ticks = 0;
  int first_n = -1;
  bit cnt_sys_en = 0;
  bit cnt_osc_en = 1;
  bit catch_en = 0;
  bit osc_arm = 0;
  bit mon_e;
  string mon_t;
  int gap_e;

  bit    exp_q[$];
  string tag_q[$];
  int    gap_q[$];

  always #2 clk_sys = ~clk_sys;
  always #7 clk_osc = ~clk_osc;

  tmr_prescaler dut_i (
    .clk_sys   (clk_sys),
    .rst_sys_n (rst_sys_n),
    .clk_osc   (clk_osc),
    .src_async (src_async),
    .tap_sel   (tap_sel),
    .clr_wr    (clr_wr),
    .clr_wdata (clr_wdata),
    .clr_rd    (clr_rd),
    .tick_sys  (tick_sys),
    .tick_osc  (tick_osc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [2:0] s);
    case (s)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 32;
      3'd4: return 64;
      3'd5: return 128;
      3'd6: return 256;
      default: return 1024;
    endcase
  endfunction

  // system-domain scoreboard monitor
  always @(negedge clk_sys) begin
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      chk(mon_t, {31'd0, tick_sys}, {31'd0, mon_e});
    end
    if (cnt_sys_en && tick_sys) sys_ticks++;
  end

  // oscillator-domain monitors
  always @(posedge clk_osc) osc_n++;

  always @(negedge clk_osc) begin
    if (cnt_osc_en && tick_osc) osc_ticks++;
    if (catch_en && tick_osc) begin
      first_n  = osc_n;
      catch_en = 0;
    end
    osc_gap++;
    if (tick_osc) begin
      if (osc_arm && gap_q.size() > 0) begin
        gap_e = gap_q.pop_front();
        chk("R1 osc strobe spacing", osc_gap, gap_e);
      end
      osc_gap = 0;
    end
  end

  // entered and left at posedge + 1 ns
  task automatic sys_clear(input logic [2:0] s, input string t);
    tap_sel = s; clr_wr = 1'b1; clr_wdata = 1'b1;
    @(negedge clk_sys);
    chk({t, " R6 readback in write cycle"}, {31'd0, clr_rd}, 0);
    @(posedge clk_sys); #1;
    clr_wr = 1'b0; clr_wdata = 1'b0; k = 0;
    exp_q.push_back(1'b0); tag_q.push_back({t, " R4 R2 restart edge"});
  endtask

  task automatic sys_run(input logic [2:0] s, input int n, input bit wr0, input string t);
    int d;
    tap_sel = s;
    d = div_of(s);
    if (wr0) begin clr_wr = 1'b1; clr_wdata = 1'b0; end
    for (int j = k + 1; j <= k + n; j++) begin
      exp_q.push_back((d != 0) && (j % d == 0));
      tag_q.push_back(t);
    end
    @(posedge clk_sys); #1;
    clr_wr = 1'b0;
    repeat (n - 1) @(posedge clk_sys);
    #1;
    k += n;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk_sys);
    @(posedge clk_sys); #1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_sys);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int wait_n;
    // R10 reset state
    repeat (4) @(negedge clk_sys);
    chk("R10 tick_sys in reset", {31'd0, tick_sys}, 0);
    chk("R10 tick_osc in reset", {31'd0, tick_osc}, 0);
    chk("R10 clr_rd in reset", {31'd0, clr_rd}, 0);
    @(posedge clk_sys); #1;
    rst_sys_n = 1'b1;
    repeat (5) @(posedge clk_sys); #1;

    // R1 R2 every rate from a fresh restart
    sys_clear(3'd1, "R1 div1");
    sys_run(3'd1, 20, 0, "R1 R2 div1");
    for (int s = 2; s < 8; s++) begin
      sys_clear(3'(s), "R1 divided");
      sys_run(3'(s), 2 * div_of(3'(s)) + 3, 0, "R1 R2 divided tap");
    end
    drain();

    // R3 stop keeps counting
    sys_clear(3'd0, "R3 stop");
    sys_run(3'd0, 43, 0, "R3 stop no strobe");
    sys_run(3'd2, 40, 0, "R3 resume keeps phase");
    drain();

    // R5 write of zero ignored
    sys_clear(3'd3, "R5 setup");
    sys_run(3'd3, 20, 0, "R5 before write zero");
    sys_run(3'd3, 60, 1, "R5 write zero keeps phase");
    drain();
    @(negedge clk_sys);
    chk("R6 readback idle sys mode", {31'd0, clr_rd}, 0);
    @(posedge clk_sys); #1;

    // R9 oscillator prescaler idle in system mode
    cnt_osc_en = 0;
    chk("R9 tick_osc idle in sys mode", osc_ticks, 0);

    // oscillator mode
    src_async = 1'b1; tap_sel = 3'd7;
    repeat (4) @(posedge clk_sys); #1;
    sys_ticks = 0; cnt_sys_en = 1;
    repeat (300) @(posedge clk_osc);
    @(posedge clk_sys); #1;
    clr_wr = 1'b1; clr_wdata = 1'b1;
    wait_n = osc_n; catch_en = 1;
    @(posedge clk_sys); #1;
    clr_wr = 1'b0; clr_wdata = 1'b0;
    @(negedge clk_sys);
    chk("R7 readback set after write", {31'd0, clr_rd}, 1);
    for (int i = 0; i < 300 && clr_rd; i++) @(negedge clk_sys);
    chk("R7 readback cleared after handshake", {31'd0, clr_rd}, 0);
    for (int i = 0; i < 1200 && catch_en; i++) @(posedge clk_osc);
    chk("R8 first strobe seen", {31'd0, catch_en}, 0);
    chk("R8 first strobe not early", {31'd0, (first_n - wait_n) >= 1024}, 1);
    chk("R8 first strobe not late", {31'd0, (first_n - wait_n) <= 1034}, 1);

    // R1 spacing in the oscillator domain
    tap_sel = 3'd2;
    repeat (30) @(posedge clk_osc);
    for (int i = 0; i < 5; i++) gap_q.push_back(8);
    osc_arm = 1;
    for (int i = 0; i < 200 && gap_q.size() > 0; i++) @(posedge clk_osc);
    chk("R1 osc spacing items consumed", gap_q.size(), 0);
    osc_arm = 0;

    // R11 second write during pending handshake
    @(posedge clk_sys); #1;
    clr_wr = 1'b1; clr_wdata = 1'b1;
    @(posedge clk_sys); #1;
    clr_wr = 1'b0;
    @(posedge clk_sys); #1;
    clr_wr = 1'b1;
    @(posedge clk_sys); #1;
    clr_wr = 1'b0; clr_wdata = 1'b0;
    @(negedge clk_sys);
    chk("R11 readback held after second write", {31'd0, clr_rd}, 1);
    for (int i = 0; i < 600 && clr_rd; i++) @(negedge clk_sys);
    chk("R11 readback clears after both rounds", {31'd0, clr_rd}, 0);
    chk("R9 tick_sys idle in osc mode", sys_ticks, 0);

    // back to system mode
    @(posedge clk_sys); #1;
    src_async = 1'b0;
    @(negedge clk_sys);
    chk("R6 readback zero back in sys mode", {31'd0, clr_rd}, 0);
    repeat (10) @(posedge clk_osc);
    osc_ticks = 0; cnt_osc_en = 1;
    repeat (50) @(posedge clk_osc);
    chk("R9 tick_osc stops in sys mode", osc_ticks, 0);
    finish_run();
  end
endmodule